// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit connects an integer execute stage to a data memory port that is one 32-bit word wide. It takes the raw instruction word of a byte, halfword or word load or store, together with the base register value and the store source value. From these it forms the byte address and presents an aligned word request that carries per-lane write enables. For stores it moves the source data onto the lanes that the low address bits select. For loads it takes the addressed lanes out of the returned word and extends the value to 32 bits, with or without sign.

An operation is offered with `op_valid` and is taken on any clock edge where `op_ready` is high. An access that is misaligned or has an illegal encoding issues no memory traffic. Instead it raises a one-cycle flag. A legal access holds its request until the memory signals ready. A load then returns its value with a one-cycle `ld_valid` pulse.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective byte address is the base value plus the 12-bit offset sign-extended to 32 bits. `mem_addr` carries its bits [31:2].
- R2: A load takes its offset from instruction bits [31:20]. A store builds its offset with instruction bits [31:25] as offset[11:5] and bits [11:7] as offset[4:0].
- R3: Byte lanes are little-endian. Lane k is data bits [8k+7:8k] and holds byte address offset k. `mem_be` is 0001 shifted left by the low two address bits for a byte access, 0011 shifted left by them for a halfword, and 1111 for a word.
- R4: Store write data has the source byte [7:0] copied onto all four lanes for a byte store, the source halfword [15:0] copied onto both halves for a halfword store, and the whole source for a word store. In memory only the enabled lanes change.
- R5: The funct3 field is instruction bits [14:12]. LB (000) and LH (001) sign-extend the selected byte or halfword, and LW (010) returns the whole word.
- R6: LBU (100) and LHU (101) zero-extend the selected byte or halfword.
- R7: A halfword access at an odd address, or a word access whose low two address bits are not 00, raises `misalign` for one cycle, starting one cycle after acceptance. It issues no memory request.
- R8: The load opcode is 0000011 and the store opcode is 0100011. Store funct3 values 000/001/010 are legal. Any other opcode or funct3 raises `illegal` for one cycle, starting one cycle after acceptance, and issues no request. `illegal` has priority over `misalign`.
- R9: `mem_req` rises on the cycle after acceptance. It holds with a stable address, enables and data until it is accepted on an edge where `mem_ready` is high. Read data is valid one cycle after that edge. `ld_valid` is a single-cycle pulse that starts two edges after the accepting edge.
- R10: `op_ready` is low while a legal access is in flight. `mem_we` is high only for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | Unit can accept an operation |
| instr | input | 32 | Raw instruction word |
| base_val | input | 32 | Base register value |
| src_val | input | 32 | Store source register value |
| mem_req | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid one cycle after acceptance |
| ld_valid | output | 1 | Load result pulse |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned access pulse |
| illegal | output | 1 | Illegal encoding pulse |

## Verification
The bench targets bytes whose top bit is set, so that a unit which mixes up sign and zero extension returns a wrong upper half. It uses store offsets whose low five bits and high seven bits differ, so that a store which reads its offset from the load field goes to the wrong word. It checks every lane of byte stores against a reference memory image, which catches a unit that copies data onto the wrong lane or enables too many lanes and so corrupts the neighbouring bytes. It also sends misaligned halfwords and words and reserved funct3 codes. A unit that let any of these through would issue a memory request, or would raise the wrong flag when an encoding is both illegal and misaligned.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    acc_size_e size;
    logic      zext;
    logic [11:0] offset;
    logic      bad;
  } acc_dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [31:0] instr,
  output acc_dec_t    dec
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic       ld_ok;
  logic       st_ok;
  logic       unused_fields;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign unused_fields = ^instr[19:15];

  always_comb begin
    ld_ok = (opc == OPC_LOAD) &&
            (f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b010 ||
             f3 == 3'b100 || f3 == 3'b101);
    st_ok = (opc == OPC_STORE) &&
            (f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b010);
    dec.is_load  = (opc == OPC_LOAD);
    dec.is_store = (opc == OPC_STORE);
    dec.bad      = !(ld_ok || st_ok);
    dec.zext     = f3[2];
    case (f3[1:0])
      2'b00:   dec.size = SZ_BYTE;
      2'b01:   dec.size = SZ_HALF;
      default: dec.size = SZ_WORD;
    endcase
    if (opc == OPC_STORE) dec.offset = {instr[31:25], instr[11:7]};
    else                  dec.offset = instr[31:20];
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  acc_size_e       size,
  input  logic [LW-1:0]   lane,
  input  logic [DW-1:0]   src,
  output logic [NB-1:0]   be,
  output logic [DW-1:0]   wdata
);
  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: begin
          wdata[8*k +: 8] = src[7:0];
          be[k]           = (lane == LW'(k));
        end
        SZ_HALF: begin
          wdata[8*k +: 8] = src[8*(k%2) +: 8];
          be[k]           = (lane[LW-1:1] == (LW-1)'(k/2));
        end
        default: begin
          wdata[8*k +: 8] = src[8*k +: 8];
          be[k]           = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [DW-1:0] rdata,
  input  logic [LW-1:0] lane,
  input  acc_size_e     size,
  input  logic          zext,
  output logic [DW-1:0] value
);
  logic [DW-1:0] shifted;
  logic          sgn_b;
  logic          sgn_h;

  assign shifted = rdata >> {lane, 3'b000};
  assign sgn_b   = !zext && shifted[7];
  assign sgn_h   = !zext && shifted[15];

  always_comb begin
    case (size)
      SZ_BYTE: value = {{(DW-8){sgn_b}}, shifted[7:0]};
      SZ_HALF: value = {{(DW-16){sgn_h}}, shifted[15:0]};
      default: value = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB),
  localparam int WAW = AW - LW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [31:0]    instr,
  input  logic [AW-1:0]  base_val,
  input  logic [DW-1:0]  src_val,
  output logic           mem_req,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [WAW-1:0] mem_addr,
  output logic [NB-1:0]  mem_be,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           ld_valid,
  output logic [DW-1:0]  ld_data,
  output logic           misalign,
  output logic           illegal
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  state_e        state_q;
  acc_dec_t      dec;
  logic [AW-1:0] eff;
  logic [LW-1:0] lane;
  logic          mis;
  logic [NB-1:0] be_c;
  logic [DW-1:0] wdata_c;
  logic [DW-1:0] ld_value;
  logic [LW-1:0] lane_q;
  acc_size_e     size_q;
  logic          zext_q;

  lsu_decode u_dec (.instr(instr), .dec(dec));

  assign eff  = base_val + {{(AW-12){dec.offset[11]}}, dec.offset};
  assign lane = eff[LW-1:0];

  always_comb begin
    case (dec.size)
      SZ_HALF: mis = lane[0];
      SZ_WORD: mis = |lane;
      default: mis = 1'b0;
    endcase
  end

  lsu_store_steer #(.DW(DW)) u_steer (
    .size(dec.size), .lane(lane), .src(src_val), .be(be_c), .wdata(wdata_c)
  );

  lsu_load_extract #(.DW(DW)) u_ext (
    .rdata(mem_rdata), .lane(lane_q), .size(size_q), .zext(zext_q), .value(ld_value)
  );

  assign op_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      lane_q    <= '0;
      size_q    <= SZ_BYTE;
      zext_q    <= 1'b0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      misalign  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      ld_valid <= 1'b0;
      misalign <= 1'b0;
      illegal  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (op_valid) begin
            if (dec.bad) begin
              illegal <= 1'b1;
            end else if (mis) begin
              misalign <= 1'b1;
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= dec.is_store;
              mem_addr  <= eff[AW-1:LW];
              mem_be    <= be_c;
              mem_wdata <= wdata_c;
              lane_q    <= lane;
              size_q    <= dec.size;
              zext_q    <= dec.zext;
              state_q   <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            state_q <= mem_we ? ST_IDLE : ST_WAIT;
          end
        end
        default: begin
          ld_valid <= 1'b1;
          ld_data  <= ld_value;
          state_q  <= ST_IDLE;
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)); // R9
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_be != '0); // R3
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    misalign || illegal |-> !mem_req); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(misalign && illegal)); // R8
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_req && mem_ready && !mem_we, 2)); // R9
  AST_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !op_ready); // R10
endmodule

// File: tb/lsu_lane_unit_tb_top.sv
module lsu_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic [31:0] src_val = '0;
  logic        mem_req;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        misalign;
  logic        illegal;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int acc_mark = 0;
  bit done = 0;
  logic [31:0] mem_q [16];
  logic [31:0] ref_mem [16];

  always #5 clk = ~clk;

  lsu_lane_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .instr(instr), .base_val(base_val), .src_val(src_val),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .misalign(misalign), .illegal(illegal)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ready) begin
      acc_mark  <= cyc;
      mem_rdata <= mem_q[mem_addr[3:0]];
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem_q[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  always @(negedge clk) mem_ready = ($urandom_range(0, 3) != 0);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ld(input logic [2:0] f3, input logic [11:0] off);
    return {off, 5'd3, f3, 5'd7, 7'b0000011};
  endfunction

  function automatic logic [31:0] mk_st(input logic [2:0] f3, input logic [11:0] off);
    return {off[11:5], 5'd9, 5'd3, f3, off[4:0], 7'b0100011};
  endfunction

  task automatic do_op(input logic [31:0] ins, input logic [31:0] base, input logic [31:0] src);
    logic [6:0]  opc = ins[6:0];
    logic [2:0]  f3 = ins[14:12];
    bit          is_ld = (opc == 7'b0000011);
    bit          is_st = (opc == 7'b0100011);
    logic [11:0] off = is_st ? {ins[31:25], ins[11:7]} : ins[31:20];
    logic [31:0] eff = base + {{20{off[11]}}, off};
    logic [1:0]  lane = eff[1:0];
    logic [3:0]  idx = eff[5:2];
    bit bad = !((is_ld && (f3 inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5})) ||
                (is_st && (f3 inside {3'd0, 3'd1, 3'd2})));
    bit mis = (f3[1:0] == 2'd1 && lane[0]) || (f3[1:0] == 2'd2 && lane != 2'd0);
    logic [3:0]  ebe;
    logic [31:0] ewd;
    logic [31:0] sh;
    logic [31:0] exp;
    int t;
    case (f3[1:0])
      2'd0: begin ebe = 4'b0001 << lane; ewd = {4{src[7:0]}}; end
      2'd1: begin ebe = 4'b0011 << lane; ewd = {2{src[15:0]}}; end
      default: begin ebe = 4'b1111; ewd = src; end
    endcase
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; instr = ins; base_val = base; src_val = src;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    if (bad) begin
      chk(illegal == 1'b1, "R8 illegal flag", {31'd0, illegal}, 32'd1);
      chk(misalign == 1'b0, "R8 priority over misalign", {31'd0, misalign}, 32'd0);
      chk(mem_req == 1'b0, "R8 no request", {31'd0, mem_req}, 32'd0);
    end else if (mis) begin
      chk(misalign == 1'b1, "R7 misalign flag", {31'd0, misalign}, 32'd1);
      chk(mem_req == 1'b0 && illegal == 1'b0, "R7 no request", {31'd0, mem_req}, 32'd0);
    end else begin
      chk(mem_req == 1'b1, "R9 request raised", {31'd0, mem_req}, 32'd1);
      chk(mem_addr == eff[31:2], "R1 R2 word address", {2'b0, mem_addr}, {2'b0, eff[31:2]});
      chk(mem_be == ebe, "R3 byte enables", {28'd0, mem_be}, {28'd0, ebe});
      chk(mem_we == is_st && op_ready == 1'b0, "R10 write flag and busy", {31'd0, mem_we}, {31'd0, is_st});
      if (is_st) chk(mem_wdata == ewd, "R4 write data", mem_wdata, ewd);
      t = 0;
      if (is_ld) begin
        while (!ld_valid && t < 100) begin @(negedge clk); t++; end
        sh = ref_mem[idx] >> (8 * lane);
        case (f3)
          3'd0: exp = {{24{sh[7]}}, sh[7:0]};
          3'd1: exp = {{16{sh[15]}}, sh[15:0]};
          3'd4: exp = {24'd0, sh[7:0]};
          3'd5: exp = {16'd0, sh[15:0]};
          default: exp = sh;
        endcase
        chk(ld_valid == 1'b1 && cyc == acc_mark + 2, "R9 load latency", cyc, acc_mark + 2);
        chk(ld_data == exp, f3[2] ? "R6 zero-extended load" : "R5 signed/word load", ld_data, exp);
        @(negedge clk);
        chk(ld_valid == 1'b0, "R9 single pulse", {31'd0, ld_valid}, 32'd0);
      end else begin
        while (!op_ready && t < 100) begin @(negedge clk); t++; end
        for (int k = 0; k < 4; k++)
          if (ebe[k]) ref_mem[idx][8*k +: 8] = ewd[8*k +: 8];
        chk(mem_q[idx] == ref_mem[idx], "R4 R3 memory image", mem_q[idx], ref_mem[idx]);
      end
    end
  endtask

  task automatic at_addr(input logic [31:0] ins_off_ld, input bit st, input logic [2:0] f3,
                         input logic [11:0] off, input logic [31:0] target, input logic [31:0] src);
    logic [31:0] base = target - {{20{off[11]}}, off};
    logic [31:0] ins = st ? mk_st(f3, off) : mk_ld(f3, off);
    if (ins_off_ld != 32'd0) ins = ins_off_ld;
    do_op(ins, base, src);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      mem_q[i] = $urandom();
      ref_mem[i] = mem_q[i];
    end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_req == 1'b0 && ld_valid == 1'b0, "R9 reset idle", {31'd0, mem_req}, 32'd0);
    chk(misalign == 1'b0 && illegal == 1'b0, "R7 R8 reset flags", {30'd0, misalign, illegal}, 32'd0);
    chk(op_ready == 1'b1, "R10 reset ready", {31'd0, op_ready}, 32'd1);

    // directed: sign-bit bytes on each lane, R5 and R6
    at_addr(0, 1, 3'd2, 12'h010, 32'h0000_0010, 32'h80F1_7F82);
    for (int l = 0; l < 4; l++) begin
      at_addr(0, 0, 3'd0, 12'h7FC, 32'h0000_0010 + l, 0);
      at_addr(0, 0, 3'd4, 12'h800, 32'h0000_0010 + l, 0);
    end
    at_addr(0, 0, 3'd1, 12'hFFE, 32'h0000_0012, 0);
    at_addr(0, 0, 3'd5, 12'h002, 32'h0000_0012, 0);
    at_addr(0, 0, 3'd2, 12'hF00, 32'hABC0_0010, 0);
    // store offset split across two fields, R2
    at_addr(0, 1, 3'd0, 12'h7E5, 32'h0000_0025, 32'h1234_56A5);
    at_addr(0, 1, 3'd1, 12'h81A, 32'h0000_0036, 32'hCAFE_BEEF);
    for (int l = 0; l < 4; l++) at_addr(0, 1, 3'd0, 12'h004, 32'h0000_0020 + l, 32'h11 * (l + 1));
    at_addr(0, 0, 3'd2, 12'h004, 32'h0000_0020, 0);
    // misaligned, R7
    at_addr(0, 0, 3'd1, 12'h001, 32'h0000_0001, 0);
    at_addr(0, 0, 3'd2, 12'h003, 32'h0000_0003, 0);
    at_addr(0, 1, 3'd2, 12'h002, 32'h0000_0002, 32'h5);
    at_addr(0, 1, 3'd1, 12'h003, 32'h0000_0003, 32'h5);
    // illegal, R8 (reserved funct3 with a misaligned address too)
    at_addr(0, 0, 3'd3, 12'h001, 32'h0000_0001, 0);
    at_addr(0, 1, 3'd4, 12'h000, 32'h0000_0000, 0);
    at_addr(0, 0, 3'd6, 12'h000, 32'h0000_0004, 0);
    at_addr(32'h0000_0013, 0, 3'd0, 12'h000, 32'h0000_0000, 0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0]  f3 = 3'($urandom_range(0, 7));
      bit          st = bit'($urandom_range(0, 1));
      logic [11:0] off = 12'($urandom());
      logic [31:0] tgt = $urandom();
      logic [31:0] other = ($urandom_range(0, 19) == 0) ? {$urandom(), 7'b0110011} : 32'd0;
      if ($urandom_range(0, 3) != 0) f3 = st ? 3'($urandom_range(0, 2)) : (3'($urandom_range(0, 1)) << 2 | 3'($urandom_range(0, 2)));
      at_addr(other, st, f3, off, tgt, $urandom());
    end
    done = 1;
    finish_run();
  end
endmodule